// File: doc/BRIEF.md
# Sequence-Driven Fault Scan Mode Controller

This block decides when an LED sink driver leaves ordinary display operation and enters a fault-scan mode, and when it returns. Two control pins that normally carry the output-enable and the latch strobe are sampled on every rising clock edge. A five-sample pattern on that pin pair switches the block into scan mode. A second five-sample pattern, which differs from the first only in its fourth sample, switches it back. A separate active-low force pin also holds the block in scan mode for as long as it is low.

While the block is in scan mode, the host turns all outputs on and holds the enable pin low for the test. Each channel's open-line or short comparator gives one result bit, where 1 means a fault. When the enable pin returns high, the block captures the result bits and pulses a load strobe for one cycle. The shift register uses that strobe to load the results in parallel and send them out serially in the ordinary frame format.

The recogniser is a state machine with six states. RS_IDLE means nothing has matched. RS_STEP1, RS_STEP2 and RS_STEP3 mean the first one, two or three samples have matched. RS_ENT4 means the fourth sample selected the entry pattern, and RS_RES4 means it selected the resume pattern. The transitions are:

- advance: the sample matches the next pattern element, so the machine moves one state on.
- branch: in RS_STEP3, the fourth sample picks RS_ENT4 or RS_RES4.
- complete: in RS_ENT4 or RS_RES4, the fifth sample matches, the machine pulses enter or resume and goes back to RS_IDLE.
- restart: the sample does not match, so the machine goes to RS_STEP1 if this sample is a valid first element, and to RS_IDLE if it is not.

The mode machine has two states, MD_NORMAL and MD_DETECT. The enter transition takes MD_NORMAL to MD_DETECT on an entry completion. The resume transition takes MD_DETECT to MD_NORMAL on a resume completion. A completion of either pattern in the other state is ignored.

Top module: `fsc_ctrl`

## Requirements
- R1: During reset and right after it, det_mode is 0, res_load is 0 and res_bits is 0.
- R2: In MD_NORMAL, the pin pair (ctl_en, ctl_latch) sampled on five consecutive rising edges as (1,0), (0,0), (1,0), (1,1), (1,0) sets det_mode to 1 directly after the fifth edge. det_mode stays 0 after the fourth edge.
- R3: In MD_DETECT, the samples (1,0), (0,0), (1,0), (1,0), (1,0) on five consecutive edges return the mode to MD_NORMAL. det_mode reads 0 directly after the fifth edge, provided force_det_n is 1 on that edge.
- R4: A sample that does not continue a partial pattern restarts recognition. That sample counts as the first element if it is (1,0), and otherwise recognition starts from nothing. So a break at the fifth sample prevents the mode change.
- R5: An entry pattern received in MD_DETECT leaves det_mode at 1. A resume pattern received in MD_NORMAL leaves det_mode at 0.
- R6: When force_det_n is 0 on a rising edge, det_mode is 1 after that edge. When force_det_n is 1 and the mode is MD_NORMAL, det_mode is 0 after the edge.
- R7: When scan mode was entered by the pin pattern, releasing force_det_n does not clear det_mode. A resume pattern completed while force_det_n is 0 returns the mode machine to MD_NORMAL, and det_mode then drops on the first edge with force_det_n at 1.
- R8: While det_mode is 1, ctl_en sampled 0 on one edge and 1 on the next captures fault_bits into res_bits at that second edge. res_load is 1 for exactly the following cycle. Bit i of res_bits is 1 when channel i reported a fault.
- R9: While det_mode is 0, a 0-to-1 change of ctl_en leaves res_load at 0 and res_bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Shared output-enable / mode pin |
| ctl_latch | input | 1 | Shared latch-strobe / mode pin |
| force_det_n | input | 1 | Active-low force of scan mode |
| fault_bits | input | NCH | Per-channel comparator results, 1 = fault |
| det_mode | output | 1 | 1 while the block is in scan mode |
| res_load | output | 1 | One-cycle parallel-load strobe for the shift register |
| res_bits | output | NCH | Captured fault results for the parallel load |

## Verification
Clean entry and resume patterns confirm that the fourth sample alone selects which way the mode moves. The same patterns repeated in the same mode show that a completion in the wrong state is ignored. Patterns broken at the second or fifth sample, or preceded by a doubled first element, separate the restart rule from a sliding-window match. Enable pulses sent in each mode, and force-pin pulses sent with and without a pattern-held scan mode, separate the capture gating and the two ways into scan mode. Random pin streams with injected whole and corrupted patterns are then checked against a bench model.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    // Pin-pair sample encoding {ctl_en, ctl_latch}
    localparam int SMP_W = 2;
    localparam logic [SMP_W-1:0] SMP_HL = 2'b10;
    localparam logic [SMP_W-1:0] SMP_LL = 2'b00;
    localparam logic [SMP_W-1:0] SMP_HH = 2'b11;

    typedef enum logic [2:0] {
        RS_IDLE  = 3'd0,
        RS_STEP1 = 3'd1,
        RS_STEP2 = 3'd2,
        RS_STEP3 = 3'd3,
        RS_ENT4  = 3'd4,
        RS_RES4  = 3'd5
    } rs_state_t;

    typedef enum logic {
        MD_NORMAL = 1'b0,
        MD_DETECT = 1'b1
    } md_state_t;

endpackage

// File: rtl/fsc_seq_match.sv
module fsc_seq_match
    import fsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_en,
    input  logic ctl_latch,
    output logic enter_hit,
    output logic resume_hit
);

    logic [SMP_W-1:0] smp;
    rs_state_t        rs_q;
    rs_state_t        rs_next;
    rs_state_t        rs_restart;

    assign smp = {ctl_en, ctl_latch};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= RS_IDLE;
        else        rs_q <= rs_next;
    end

    // Next state: advance on a matching element, otherwise restart and
    // let the current sample open a new pattern if it can (R4).
    always_comb begin
        rs_restart = (smp == SMP_HL) ? RS_STEP1 : RS_IDLE;
        rs_next    = rs_restart;
        unique case (rs_q)
            RS_IDLE:  rs_next = rs_restart;
            RS_STEP1: if (smp == SMP_LL) rs_next = RS_STEP2;
            RS_STEP2: if (smp == SMP_HL) rs_next = RS_STEP3;
            RS_STEP3: begin
                if (smp == SMP_HH)      rs_next = RS_ENT4;
                else if (smp == SMP_HL) rs_next = RS_RES4;
            end
            RS_ENT4,
            RS_RES4:  if (smp == SMP_HL) rs_next = RS_IDLE;
            default:  rs_next = RS_IDLE;
        endcase
    end

    // Outputs: completion pulses on the fifth matching sample
    always_comb begin
        enter_hit  = 1'b0;
        resume_hit = 1'b0;
        unique case (rs_q)
            RS_ENT4: enter_hit  = (smp == SMP_HL);
            RS_RES4: resume_hit = (smp == SMP_HL);
            default: ;
        endcase
    end

endmodule

// File: rtl/fsc_mode_fsm.sv
module fsc_mode_fsm
    import fsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_hit,
    input  logic resume_hit,
    input  logic force_det_n,
    output logic det_mode
);

    md_state_t md_q;
    md_state_t md_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= MD_NORMAL;
        else        md_q <= md_next;
    end

    // A completion in the wrong mode is ignored (R5)
    always_comb begin
        md_next = md_q;
        unique case (md_q)
            MD_NORMAL: if (enter_hit)  md_next = MD_DETECT;
            MD_DETECT: if (resume_hit) md_next = MD_NORMAL;
            default:   md_next = MD_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_mode <= 1'b0;
        else        det_mode <= (md_next == MD_DETECT) | ~force_det_n;
    end

    a_r6_force_pin_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !force_det_n |=> det_mode);

endmodule

// File: rtl/fsc_result_cap.sv
module fsc_result_cap #(
    parameter int NCH = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           det_mode,
    input  logic           ctl_en,
    input  logic [NCH-1:0] fault_bits,
    output logic           res_load,
    output logic [NCH-1:0] res_bits
);

    logic en_prev;
    logic cap_now;

    // Enable pin idles high, so the history starts high to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_prev <= 1'b1;
        else        en_prev <= ctl_en;
    end

    assign cap_now = det_mode & ctl_en & ~en_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_load <= 1'b0;
        else        res_load <= cap_now;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       res_bits[ch] <= 1'b0;
            else if (cap_now) res_bits[ch] <= fault_bits[ch];
        end
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_load |=> !res_load);

endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl #(
    parameter int NCH = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_en,
    input  logic           ctl_latch,
    input  logic           force_det_n,
    input  logic [NCH-1:0] fault_bits,
    output logic           det_mode,
    output logic           res_load,
    output logic [NCH-1:0] res_bits
);

    logic enter_hit;
    logic resume_hit;

    fsc_seq_match u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_en     (ctl_en),
        .ctl_latch  (ctl_latch),
        .enter_hit  (enter_hit),
        .resume_hit (resume_hit)
    );

    fsc_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_hit   (enter_hit),
        .resume_hit  (resume_hit),
        .force_det_n (force_det_n),
        .det_mode    (det_mode)
    );

    fsc_result_cap #(.NCH(NCH)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_mode   (det_mode),
        .ctl_en     (ctl_en),
        .fault_bits (fault_bits),
        .res_load   (res_load),
        .res_bits   (res_bits)
    );

    a_r2_entry_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        enter_hit |=> det_mode);

    a_r3_resume_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_hit && force_det_n) |=> !det_mode);

    a_r9_load_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        res_load |-> $past(det_mode));

    a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_load |-> $stable(res_bits));

endmodule

// File: tb/sim_fsc_ctrl.sv
module sim_fsc_ctrl;

    localparam int NCH = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ctl_en = 1'b1;
    logic           ctl_latch = 1'b1;
    logic           force_det_n = 1'b1;
    logic [NCH-1:0] fault_bits = '0;
    logic           det_mode;
    logic           res_load;
    logic [NCH-1:0] res_bits;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state
    int             m_k = 0;
    bit             m_ent = 1'b0;
    bit             m_seqdet = 1'b0;
    bit             m_det = 1'b0;
    bit             m_oeprev = 1'b1;
    bit             m_load = 1'b0;
    logic [NCH-1:0] m_data = '0;

    always #2 clk = ~clk;

    fsc_ctrl #(.NCH(NCH)) u0 (
        .clk (clk), .rst_n (rst_n), .ctl_en (ctl_en), .ctl_latch (ctl_latch),
        .force_det_n (force_det_n), .fault_bits (fault_bits),
        .det_mode (det_mode), .res_load (res_load), .res_bits (res_bits)
    );

    task automatic check(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int restart_k(bit oe, bit le);
        return (oe && !le) ? 1 : 0;
    endfunction

    // Advance the bench model by one sampled edge
    task automatic model_edge(bit oe, bit le, bit fdn, logic [NCH-1:0] f);
        bit prev_det = m_det;
        bit hit_e = 1'b0;
        bit hit_r = 1'b0;
        case (m_k)
            0: m_k = restart_k(oe, le);
            1: m_k = (!oe && !le) ? 2 : restart_k(oe, le);
            2: m_k = (oe && !le) ? 3 : restart_k(oe, le);
            3: begin
                if (oe && le)       begin m_k = 4; m_ent = 1'b1; end
                else if (oe && !le) begin m_k = 4; m_ent = 1'b0; end
                else m_k = restart_k(oe, le);
            end
            default: begin
                if (oe && !le) begin
                    m_k = 0;
                    if (m_ent) hit_e = 1'b1; else hit_r = 1'b1;
                end else m_k = restart_k(oe, le);
            end
        endcase
        if (hit_e && !m_seqdet) m_seqdet = 1'b1;
        else if (hit_r && m_seqdet) m_seqdet = 1'b0;
        m_det = m_seqdet | !fdn;
        if (prev_det && oe && !m_oeprev) begin
            m_data = f;
            m_load = 1'b1;
        end else m_load = 1'b0;
        m_oeprev = oe;
    endtask

    task automatic step(bit oe, bit le, bit fdn, logic [NCH-1:0] f);
        @(negedge clk);
        ctl_en = oe; ctl_latch = le; force_det_n = fdn; fault_bits = f;
        @(posedge clk);
        #1;
        model_edge(oe, le, fdn, f);
        check("R2 det_mode vs model", NCH'(det_mode), NCH'(m_det));
        check("R8 res_load vs model", NCH'(res_load), NCH'(m_load));
        check("R8 res_bits vs model", res_bits, m_data);
    endtask

    task automatic send_entry(bit fdn);
        step(1, 0, fdn, '0); step(0, 0, fdn, '0); step(1, 0, fdn, '0);
        step(1, 1, fdn, '0); step(1, 0, fdn, '0);
    endtask

    task automatic send_resume(bit fdn);
        step(1, 0, fdn, '0); step(0, 0, fdn, '0); step(1, 0, fdn, '0);
        step(1, 0, fdn, '0); step(1, 0, fdn, '0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1, 1, 1, '0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] pat;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 det_mode in reset", NCH'(det_mode), '0);
        check("R1 res_load in reset", NCH'(res_load), '0);
        check("R1 res_bits in reset", res_bits, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        check("R1 det_mode after reset", NCH'(det_mode), '0);

        // R2: clean entry pattern
        step(1, 0, 1, '0); step(0, 0, 1, '0); step(1, 0, 1, '0); step(1, 1, 1, '0);
        check("R2 det_mode after 4th sample", NCH'(det_mode), '0);
        step(1, 0, 1, '0);
        check("R2 det_mode after 5th sample", NCH'(det_mode), 1);
        idle(2);

        // R5: second entry while already in scan mode
        send_entry(1);
        idle(1);
        check("R5 repeated entry keeps mode", NCH'(det_mode), 1);

        // R8: capture on enable rising edge in scan mode
        pat = 24'hA5_3C_81;
        step(0, 1, 1, '0);
        step(1, 1, 1, pat);
        check("R8 res_load after rise", NCH'(res_load), 1);
        check("R8 res_bits captured", res_bits, pat);
        step(1, 1, 1, 24'h0F0F0F);
        check("R8 res_load one cycle only", NCH'(res_load), '0);
        check("R8 res_bits held", res_bits, pat);

        // R3: resume pattern
        send_resume(1);
        check("R3 det_mode after resume", NCH'(det_mode), '0);
        idle(2);

        // R5: resume while already normal
        send_resume(1);
        idle(1);
        check("R5 repeated resume keeps normal", NCH'(det_mode), '0);

        // R9: enable rise in normal mode
        pat = res_bits;
        step(0, 1, 1, 24'hFFFFFF);
        step(1, 1, 1, 24'hFFFFFF);
        check("R9 no load in normal", NCH'(res_load), '0);
        check("R9 res_bits unchanged", res_bits, pat);

        // R4: break at the fifth sample
        step(1, 0, 1, '0); step(0, 0, 1, '0); step(1, 0, 1, '0);
        step(1, 1, 1, '0); step(0, 0, 1, '0); step(1, 0, 1, '0);
        idle(1);
        check("R4 broken pattern no entry", NCH'(det_mode), '0);
        // R4: doubled first element restarts and still counts as step one
        step(1, 0, 1, '0); step(1, 0, 1, '0); step(0, 0, 1, '0);
        step(1, 0, 1, '0); step(1, 1, 1, '0); step(1, 0, 1, '0);
        check("R4 restart counts first element", NCH'(det_mode), 1);
        idle(1);
        send_resume(1);
        idle(1);

        // R6: force pin
        step(1, 1, 0, '0);
        check("R6 force low sets mode", NCH'(det_mode), 1);
        step(1, 1, 1, '0);
        check("R6 force release clears mode", NCH'(det_mode), '0);

        // R7: pattern-held mode survives force release
        send_entry(1);
        step(1, 1, 0, '0);
        step(1, 1, 1, '0);
        check("R7 release keeps pattern mode", NCH'(det_mode), 1);
        send_resume(0);
        check("R7 force holds during resume", NCH'(det_mode), 1);
        step(1, 1, 1, '0);
        check("R7 mode drops after release", NCH'(det_mode), '0);

        // Random stream with injected patterns, checked against the model
        for (int n = 0; n < 600; n++) begin
            int kind = int'($urandom % 4);
            if (kind == 0) send_entry(($urandom % 16) != 0);
            else if (kind == 1) send_resume(($urandom % 16) != 0);
            else if (kind == 2) begin
                int bad = int'($urandom % 5);
                for (int j = 0; j < 5; j++) begin
                    bit oe = (j != 1);
                    bit le = (j == 3);
                    if (j == bad) begin oe = $urandom % 2; le = $urandom % 2; end
                    step(oe, le, ($urandom % 16) != 0, NCH'($urandom));
                end
            end else begin
                for (int j = 0; j < 1 + int'($urandom % 3); j++)
                    step($urandom % 2, $urandom % 2, ($urandom % 16) != 0, NCH'($urandom));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule